// File: doc/BRIEF.md
# Two-Wire Configuration Memory Slave

This block lets an external programmer load and read back a small byte-wide configuration store over a two-wire serial bus. The bus has a clock line driven by the master and a shared, pulled-up data line. The slave never drives the data line high. It only asserts a pull-low enable. Both bus lines are oversampled by the system clock, and any data-line edge seen while the bus clock is high is decoded as a start or stop condition instead of data.

A write message carries the device address, a 16-bit memory address sent high byte first, and any number of data bytes. The data bytes are held in a small staging buffer. The closing stop condition launches a self-timed write cycle. During that cycle the bus is ignored, the busy flag is high, and the device address is not acknowledged, so the master finds out when the cycle has finished by sending the address again until it is acknowledged. The staged bytes land in the array in the last clock of the cycle.

Reads always begin at the internal address pointer. They continue byte by byte while the master acknowledges. A write message that stops right after its address bytes only moves the pointer, which is the usual way to aim a read.

Top module: `cfgmem_slave`

## Requirements
- R1: The slave samples data on the rising edge of the bus clock and changes its pull-low enable only while the bus clock is low. Bytes travel most significant bit first.
- R2: A start condition (data falling while the clock is high) makes the slave wait for a new device address from any state outside the write cycle. Any partly received byte is dropped.
- R3: The device address byte is the 7-bit identifier `DEV_ID` followed by a direction bit (0 = write, 1 = read). On a match the slave pulls the acknowledge bit low. On a mismatch it leaves the line released and ignores the bus until the next start.
- R4: In a write message, every address and data byte is acknowledged. The memory address is the high byte followed by the low byte, and only its low `ADDR_W` bits select a location.
- R5: A read returns the byte at the address pointer. The slave releases the line during the master's acknowledge bit. A low acknowledge fetches the next byte, and a high one sends the slave back to idle.
- R6: The address pointer advances after every byte written or read, and it wraps from the last location to location 0.
- R7: A stop condition (data rising while the clock is high) after at least one data byte raises `busy_o` on the next clock, and `busy_o` stays high for exactly `WR_CYCLES` clocks. A stop that follows no data byte leaves `busy_o` low.
- R8: Staged bytes reach the array only at the end of the write cycle. If a start comes before the stop, the staged bytes are discarded.
- R9: While `busy_o` is high, both bus lines are ignored. The device address is not acknowledged, and no message has any effect.
- R10: A message stages at most `BUF_N` data bytes. Bytes beyond that are still acknowledged and still advance the pointer, but they are discarded.
- R11: While `prog_en_n` is high, the slave is idle, releases the data line and discards staged bytes.
- R12: After reset every array location reads 0, the pointer is 0, the data line is released and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en_n | input | 1 | Active-low enable for bus handling |
| sck_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Level on the shared data line |
| sda_pull_o | output | 1 | When high, the data line is pulled low |
| busy_o | output | 1 | High during the internal write cycle |

## Verification
The bench builds the slave with `ADDR_W`=5, `BUF_N`=4, `WR_CYCLES`=40 and `DEV_ID`=7'h5A. The 32-byte array puts the pointer wrap within reach of a three-byte write starting at location 30. It also makes a 16-bit address with high bits set fold onto a location that was already written. A four-entry buffer lets a six-byte message overflow it. Forty clocks is shorter than one bus byte, so the first poll after a stop is always refused, the second is accepted, and a message started during the cycle is caught partway by its end.

// File: rtl/cfgmem_slave.sv
module cfgmem_slave #(
  parameter int         ADDR_W    = 6,
  parameter int         BUF_N     = 8,
  parameter int         WR_CYCLES = 64,
  parameter logic [6:0] DEV_ID    = 7'h52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_en_n,
  input  logic sck_i,
  input  logic sda_i,
  output logic sda_pull_o,
  output logic busy_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int BCW   = $clog2(BUF_N + 1);
  localparam int BIW   = (BUF_N > 1) ? $clog2(BUF_N) : 1;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD, ST_BUSY} st_t;

  logic sck_s, sck_p, sda_s, sda_p;
  logic sck_rise, sck_fall, start_det, stop_det;

  st_t                state;
  logic [3:0]         cnt;
  logic [7:0]         sh, ahi;
  logic [ADDR_W-1:0]  ptr;
  logic               ack_ph, ack_drv, mack;
  logic [TW-1:0]      timer;
  logic [BCW-1:0]     bcnt;
  logic [7:0]         mem   [DEPTH];
  logic [ADDR_W-1:0]  buf_a [BUF_N];
  logic [7:0]         buf_d [BUF_N];
  logic [15:0]        full_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= 1'b1; sck_p <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      sck_s <= sck_i; sck_p <= sck_s; sda_s <= sda_i; sda_p <= sda_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_p;
  assign sck_fall  = ~sck_s & sck_p;
  assign start_det = sck_s & sck_p & sda_p & ~sda_s;
  assign stop_det  = sck_s & sck_p & ~sda_p & sda_s;
  assign full_addr = {ahi, sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ahi     <= '0;
      ptr     <= '0;
      ack_ph  <= 1'b0;
      ack_drv <= 1'b0;
      mack    <= 1'b0;
      timer   <= '0;
      bcnt    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < BUF_N; i++) begin
        buf_a[i] <= '0;
        buf_d[i] <= '0;
      end
    end else if (state == ST_BUSY) begin
      if (timer == TW'(WR_CYCLES - 1)) begin
        for (int i = 0; i < BUF_N; i++)
          if (i < int'(bcnt)) mem[buf_a[i]] <= buf_d[i];
        bcnt  <= '0;
        timer <= '0;
        state <= ST_IDLE;
      end else begin
        timer <= timer + TW'(1);
      end
    end else if (prog_en_n) begin
      state  <= ST_IDLE;
      ack_ph <= 1'b0;
      bcnt   <= '0;
    end else if (start_det) begin
      state  <= ST_DEV;
      cnt    <= '0;
      ack_ph <= 1'b0;
      bcnt   <= '0;
    end else if (stop_det) begin
      ack_ph <= 1'b0;
      timer  <= '0;
      state  <= (state == ST_WR && bcnt != '0) ? ST_BUSY : ST_IDLE;
    end else if (ack_ph) begin
      if (sck_rise) begin
        mack <= ~sda_s;
      end else if (sck_fall) begin
        ack_ph <= 1'b0;
        cnt    <= '0;
        if (state == ST_RD) begin
          if (mack) begin
            sh  <= mem[ptr];
            ptr <= ptr + ADDR_W'(1);
          end else begin
            state <= ST_IDLE;
          end
        end
      end
    end else if (state == ST_RD) begin
      if (sck_rise) begin
        cnt <= cnt + 4'd1;
      end else if (sck_fall) begin
        if (cnt == 4'd8) begin
          ack_ph  <= 1'b1;
          ack_drv <= 1'b0;
        end else begin
          sh <= {sh[6:0], 1'b0};
        end
      end
    end else if (state != ST_IDLE) begin
      if (sck_rise) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end else if (sck_fall && cnt == 4'd8) begin
        ack_ph  <= 1'b1;
        ack_drv <= 1'b1;
        case (state)
          ST_DEV: begin
            if (sh[7:1] != DEV_ID) begin
              ack_drv <= 1'b0;
              state   <= ST_IDLE;
            end else if (sh[0]) begin
              mack  <= 1'b1;
              state <= ST_RD;
            end else begin
              state <= ST_AHI;
            end
          end
          ST_AHI: begin
            ahi   <= sh;
            state <= ST_ALO;
          end
          ST_ALO: begin
            ptr   <= full_addr[ADDR_W-1:0];
            state <= ST_WR;
          end
          default: begin
            if (bcnt != BCW'(BUF_N)) begin
              buf_a[bcnt[BIW-1:0]] <= ptr;
              buf_d[bcnt[BIW-1:0]] <= sh;
              bcnt <= bcnt + BCW'(1);
            end
            ptr <= ptr + ADDR_W'(1);
          end
        endcase
      end
    end
  end

  assign sda_pull_o = ack_ph ? ack_drv : (state == ST_RD && !sh[7]);
  assign busy_o     = (state == ST_BUSY);

  assert_sda_stable_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_s && sck_p && !prog_en_n) |=> $stable(sda_pull_o));

  assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !prog_en_n && !busy_o) |=> (state == ST_DEV && cnt == 4'd0));

  assert_busy_from_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_det));

  assert_commit_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (bcnt == '0));

  assert_busy_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BCW'(BUF_N));

  assert_disable_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en_n |=> !sda_pull_o);

endmodule

// File: tb/cfgmem_slave_bench.sv
`timescale 1ns/1ps
module cfgmem_slave_bench;

  localparam int         AW  = 5;
  localparam int         BN  = 4;
  localparam int         WC  = 40;
  localparam logic [6:0] DID = 7'h5A;
  localparam int         H   = 4;
  localparam logic [7:0] DEVW = {DID, 1'b0};
  localparam logic [7:0] DEVR = {DID, 1'b1};

  localparam logic [23:0] VEC [5] = '{24'h0003A5, 24'h00113C, 24'h01235E, 24'h001F81, 24'hFF00C7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_en_n = 1'b1;
  logic m_sck = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull_o, busy_o;
  wire  sda_bus = m_sda & ~sda_pull_o;

  int total = 0;
  int bad = 0;
  int run = 0;
  int last_run = 0;
  logic a, allok;
  int np;
  logic [7:0] rb;
  logic [7:0] rbuf [8];

  always #10 clk = ~clk;

  cfgmem_slave #(.ADDR_W(AW), .BUF_N(BN), .WR_CYCLES(WC), .DEV_ID(DID)) u_cfgmem_slave (
    .clk(clk), .rst_n(rst_n), .prog_en_n(prog_en_n), .sck_i(m_sck), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o), .busy_o(busy_o));

  always @(negedge clk) begin
    if (busy_o) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wc(H); m_sck = 1'b1; wc(H); m_sda = 1'b0; wc(H); m_sck = 1'b0; wc(H);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wc(H); m_sck = 1'b1; wc(H); m_sda = 1'b1; wc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wc(H); m_sck = 1'b1; wc(H); m_sck = 1'b0; wc(1);
    end
    m_sda = 1'b1; wc(H); m_sck = 1'b1; wc(2);
    ackd = !sda_bus;
    wc(2); m_sck = 1'b0; wc(1);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wc(H); m_sck = 1'b1; wc(2);
      b = {b[6:0], sda_bus};
      wc(2); m_sck = 1'b0;
    end
    wc(1); m_sda = !give_ack; wc(H); m_sck = 1'b1; wc(H); m_sck = 1'b0; wc(1); m_sda = 1'b1;
  endtask

  task automatic write_msg(input logic [15:0] addr, input int n, input logic [7:0] d0,
                           output logic ok);
    logic k;
    bus_start;
    send_byte(DEVW, k); ok = k;
    send_byte(addr[15:8], k); ok &= k;
    send_byte(addr[7:0], k); ok &= k;
    for (int i = 0; i < n; i++) begin
      send_byte(d0 + 8'(i), k); ok &= k;
    end
    bus_stop;
  endtask

  task automatic set_ptr(input logic [15:0] addr);
    logic k;
    bus_start;
    send_byte(DEVW, k); send_byte(addr[15:8], k); send_byte(addr[7:0], k);
    bus_stop;
  endtask

  task automatic poll(output int n);
    logic k;
    n = 0;
    do begin
      bus_start; send_byte(DEVW, k); bus_stop; n++;
    end while (!k && n < 40);
  endtask

  task automatic read_seq(input int n);
    logic k;
    logic [7:0] b;
    bus_start;
    send_byte(DEVR, k);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      rbuf[i] = b;
    end
    bus_stop;
  endtask

  initial begin
    wc(5); rst_n = 1'b1; prog_en_n = 1'b0; wc(4);

    // reset state
    chk("R12 pull released after reset", sda_pull_o, 0);
    chk("R12 busy low after reset", busy_o, 0);
    bus_start; send_byte(DEVR, a);
    chk("R3 read address acked", a, 1);
    recv_byte(1'b0, rb); bus_stop;
    chk("R12 location 0 is zero", rb, 8'h00);

    // table of single-byte writes and readbacks
    for (int k = 0; k < 5; k++) begin
      write_msg(VEC[k][23:8], 1, VEC[k][7:0], allok);
      chk("R4 write message acked", allok, 1);
      chk("R7 busy after stop", busy_o, 1);
      poll(np);
      chk("R9 first poll refused", np > 1, 1);
      chk("R7 write cycle length", last_run, WC);
      set_ptr(VEC[k][23:8]);
      chk("R7 pointer-only message keeps busy low", busy_o, 0);
      read_seq(1);
      chk("R5 R1 readback", rbuf[0], VEC[k][7:0]);
    end
    set_ptr(16'h0003); read_seq(1);
    chk("R4 high address bits ignored", rbuf[0], 8'h5E);

    // wrap and sequential read
    write_msg(16'd30, 3, 8'hD0, allok);
    chk("R6 wrap write acked", allok, 1);
    poll(np);
    set_ptr(16'd30); read_seq(3);
    chk("R6 byte at 30", rbuf[0], 8'hD0);
    chk("R6 byte at 31", rbuf[1], 8'hD1);
    chk("R6 wrapped to 0", rbuf[2], 8'hD2);
    read_seq(1);
    chk("R6 pointer after read", rbuf[0], 8'h00);

    // overflow of the staging buffer
    write_msg(16'd10, 6, 8'hE0, allok);
    chk("R10 extra bytes acked", allok, 1);
    poll(np);
    set_ptr(16'd10); read_seq(6);
    for (int i = 0; i < 6; i++)
      chk("R10 staged bytes", rbuf[i], (i < BN) ? 8'hE0 + 8'(i) : 8'h00);

    // wrong device address
    bus_start; send_byte({7'h11, 1'b0}, a);
    chk("R3 foreign address refused", a, 0);
    send_byte(8'h00, a);
    chk("R3 bytes after refusal ignored", a, 0);
    bus_stop;
    chk("R3 no write cycle", busy_o, 0);

    // restart in the middle of a byte
    set_ptr(16'h0011);
    bus_start; send_byte(DEVW, a);
    for (int i = 0; i < 3; i++) begin
      m_sda = 1'b1; wc(H); m_sck = 1'b1; wc(H); m_sck = 1'b0; wc(1);
    end
    bus_start; send_byte(DEVR, a);
    chk("R2 address after restart acked", a, 1);
    recv_byte(1'b0, rb); bus_stop;
    chk("R2 pointer kept across restart", rb, 8'h3C);

    // start before stop discards staged bytes
    bus_start; send_byte(DEVW, a); send_byte(8'h00, a); send_byte(8'd24, a); send_byte(8'h55, a);
    bus_start; send_byte(DEVW, a); bus_stop;
    chk("R8 no cycle after restart", busy_o, 0);
    set_ptr(16'd24); read_seq(1);
    chk("R8 staged byte discarded", rbuf[0], 8'h00);

    // bus ignored during the write cycle
    write_msg(16'd21, 1, 8'h11, allok);
    bus_start; send_byte(DEVW, a);
    chk("R9 address refused while busy", a, 0);
    send_byte(8'h00, a); send_byte(8'd20, a); send_byte(8'h99, a); bus_stop;
    poll(np);
    set_ptr(16'd20); read_seq(2);
    chk("R9 message during cycle had no effect", rbuf[0], 8'h00);
    chk("R8 committed byte present", rbuf[1], 8'h11);

    // programming enable withdrawn
    bus_start; send_byte(DEVW, a); send_byte(8'h00, a); send_byte(8'd22, a); send_byte(8'h77, a);
    chk("R11 data acked before disable", a, 1);
    prog_en_n = 1'b1; wc(4);
    chk("R11 line released", sda_pull_o, 0);
    prog_en_n = 1'b0; wc(2);
    bus_stop; wc(2);
    chk("R11 no cycle after disable", busy_o, 0);
    set_ptr(16'd22); read_seq(1);
    chk("R11 staged byte dropped", rbuf[0], 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule